// File: doc/BRIEF.md
# Scan Decimating Sample Gate

The gate sits behind a converter that is paced by one free-running timer at the conversion rate. Each sample arrives as a valid/data pair. The gate keeps only the samples that belong to a scan and throws away the rest. Samples are grouped into frames of `L*(1+D)` samples, where `L` is the number of channels in one scan and `D` is the spacing factor. The first `L` samples of each frame pass to the output; the other `L*D` are dropped. The result is a train of scans separated by quiet gaps, even though the pacer itself never stops.

Alongside the gate runs a sample budget. In counted mode a load sets the budget to `scans*L*(1+D)`, and every accepted sample uses up one unit, whether it is forwarded or dropped. When the budget is used up, `done` rises and the gate accepts no further samples. In continuous mode there is no budget and `done` stays low.

A pulse on `cfg_load` applies a new configuration and restarts the gate. The spacing factor is computed outside the block: scan period divided by (conversion period × L), minus one. The scan period must be a whole multiple of `L` conversion periods.

Top module: `scan_gate`

## Requirements
- R1: Accepted samples are numbered from the last load onward, modulo the frame length `L*(1+D)`. A sample whose position is below `L` is forwarded; any other accepted sample is dropped.
- R2: With `cfg_space` = 0, every accepted sample is forwarded.
- R3: A forwarded sample appears on `out_data` with `out_valid` high in the cycle after the edge at which it was accepted. `out_valid` is high for exactly one cycle per forwarded sample and low in every other cycle.
- R4: The frame position advances only on accepted samples. It holds its value through any number of cycles with `in_valid` low.
- R5: In counted mode (`cfg_continuous` = 0), a load sets the budget to `cfg_scans*cfg_chans*(cfg_space+1)`. Every accepted sample reduces the budget by one, whether it is forwarded or dropped.
- R6: When the budget reaches zero, `done` goes high in the cycle after the last accepted sample. It stays high until the next load. While `done` is high, no sample is forwarded.
- R7: In continuous mode (`cfg_continuous` = 1), `done` never goes high and frames repeat without end.
- R8: A cycle with `cfg_load` high latches `cfg_chans`, `cfg_space`, `cfg_scans` and `cfg_continuous`. It resets the frame position and the budget, clears `done`, and drops any sample presented in that same cycle.
- R9: After reset, and until the first load, no sample is forwarded and `done` is low.
- R10: A counted-mode load with `cfg_scans` = 0 raises `done` in the cycle after the load, and nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Latch the configuration and restart the gate |
| cfg_chans | input | LEN_W | Channels per scan `L`; must be at least 1 |
| cfg_space | input | SPC_W | Spacing factor `D` |
| cfg_scans | input | SCAN_W | Number of scans in counted mode |
| cfg_continuous | input | 1 | 1 = no budget; 0 = counted mode |
| in_valid | input | 1 | An input sample is present |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | A forwarded sample is present |
| out_data | output | DATA_W | Forwarded sample |
| done | output | 1 | Counted-mode budget is used up |

## Verification
The hardest case is the frame position staying put across input gaps while the budget runs out partway through a frame. Reaching it requires a sample count that is not aligned to any burst. The stimulus sweeps every combination of `L` from 1 to 4, `D` from 0 to 3 and 0 to 2 scans, with `in_valid` held low on every fifth cycle. It keeps offering samples past the end of the budget. Reloads with a sample in the load cycle, and reloads in the middle of a frame, check that the restart takes priority over the sample arriving with it.

// File: rtl/scan_gate_pkg.sv
// Shared types for the scan gate.
// Assumes: nothing beyond IEEE 1800-2017.
package scan_gate_pkg;
    // Run state of the gate: not yet loaded, running, budget used up.
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_RUN  = 2'd1,
        GS_DONE = 2'd2
    } gate_state_e;
endpackage

// File: rtl/scan_gate_phase.sv
// Frame position counter. It tracks where the next accepted sample falls
// within a frame of chans*(space+1) samples, and reports whether that
// position lies inside the scan window (below chans).
// Assumes: chans >= 1; restart takes priority over step.
module scan_gate_phase #(
    parameter int LEN_W = 5,
    parameter int SPC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [LEN_W-1:0] chans,
    input  logic [SPC_W-1:0] space,
    output logic             pass
);
    localparam int GRP_W = LEN_W + SPC_W;

    logic [GRP_W-1:0] grp_len;
    logic [GRP_W-1:0] pos_q;
    logic             last;

    // Frame length, and whether the current position is the last one in the frame.
    always_comb begin
        grp_len = GRP_W'(chans) * (GRP_W'(space) + GRP_W'(1));
        last    = (pos_q == grp_len - GRP_W'(1));
        pass    = (pos_q < GRP_W'(chans));
    end

    // Move the position on each accepted sample, wrapping at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (restart) pos_q <= '0;
        else if (step)    pos_q <= last ? '0 : pos_q + GRP_W'(1);
    end

    // R1: the position always lies inside the frame.
    a_r1_pos_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_len != '0) |-> (pos_q < grp_len));
    // R4: the position holds while no sample is accepted.
    a_r4_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(pos_q));
    // R1: after the last position of a frame comes position zero.
    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !restart) |=> (pos_q == '0));
endmodule

// File: rtl/scan_gate_budget.sv
// Sample budget and run state. A restart loads the total and the mode.
// In counted mode each accepted sample uses one unit of the budget, and
// reaching zero ends the run.
// Assumes: step is only raised while the state is GS_RUN.
module scan_gate_budget
    import scan_gate_pkg::*;
#(
    parameter int STOP_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [STOP_W-1:0] total,
    input  logic              continuous,
    input  logic              step,
    output gate_state_e       state
);
    logic [STOP_W-1:0] rem_q;
    logic              cont_q;
    gate_state_e       state_q;

    assign state = state_q;

    // Load the budget on restart; use it up on each accepted sample in counted mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            cont_q  <= 1'b0;
            state_q <= GS_IDLE;
        end else if (restart) begin
            rem_q   <= total;
            cont_q  <= continuous;
            state_q <= (!continuous && total == '0) ? GS_DONE : GS_RUN;
        end else if (step && !cont_q) begin
            rem_q <= rem_q - STOP_W'(1);
            if (rem_q == STOP_W'(1)) state_q <= GS_DONE;
        end
    end

    // R7: continuous mode never ends.
    a_r7_cont_never_done: assert property (@(posedge clk) disable iff (!rst_n)
        cont_q |-> (state_q != GS_DONE));
    // R5: each counted sample uses exactly one unit.
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cont_q && !restart) |=> (rem_q == $past(rem_q) - STOP_W'(1)));
    // R6: done holds until the next load.
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_DONE && !restart) |=> (state_q == GS_DONE));
endmodule

// File: rtl/scan_gate_out.sv
// Output register. It captures a sample when fire is high and raises
// out_valid for one cycle. The last sample stays on out_data between fires.
// Assumes: the downstream consumer is always ready.
module scan_gate_out #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] din,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Register the forwarded sample and its one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) out_data <= din;
        end
    end

    // R3: the output carries the fired sample one cycle later.
    a_r3_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (out_valid && out_data == $past(din)));
    // R3: no valid without a fire in the cycle before.
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !out_valid);
endmodule

// File: rtl/scan_gate.sv
// Scan decimating sample gate, top level. It latches the configuration on
// load, decides which samples are accepted, and ties together the frame
// position, the budget and the output register.
// Assumes: cfg_chans >= 1; the input stream has no backpressure.
module scan_gate
    import scan_gate_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5,
    parameter int SPC_W  = 10,
    parameter int SCAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [LEN_W-1:0]  cfg_chans,
    input  logic [SPC_W-1:0]  cfg_space,
    input  logic [SCAN_W-1:0] cfg_scans,
    input  logic              cfg_continuous,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);
    localparam int STOP_W = LEN_W + SPC_W + SCAN_W;

    logic [LEN_W-1:0]  chans_q;
    logic [SPC_W-1:0]  space_q;
    logic [STOP_W-1:0] total;
    logic              accept;
    logic              pass;
    logic              fire;
    gate_state_e       state;

    // Latch the frame shape on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chans_q <= LEN_W'(1);
            space_q <= '0;
        end else if (cfg_load) begin
            chans_q <= cfg_chans;
            space_q <= cfg_space;
        end
    end

    // Budget total, and the accept/forward decision for the current input.
    always_comb begin
        total  = STOP_W'(cfg_scans) * STOP_W'(cfg_chans) * (STOP_W'(cfg_space) + STOP_W'(1));
        accept = in_valid && (state == GS_RUN) && !cfg_load;
        fire   = accept && pass;
    end

    assign done = (state == GS_DONE);

    scan_gate_phase #(.LEN_W(LEN_W), .SPC_W(SPC_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_load),
        .step    (accept),
        .chans   (chans_q),
        .space   (space_q),
        .pass    (pass)
    );

    scan_gate_budget #(.STOP_W(STOP_W)) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_load),
        .total      (total),
        .continuous (cfg_continuous),
        .step       (accept),
        .state      (state)
    );

    scan_gate_out #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .din       (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R6: nothing is forwarded once done.
    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_load) |=> !out_valid);
    // R9: nothing is forwarded before the first load.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GS_IDLE) |=> !out_valid);
    // R2: with zero spacing every accepted sample is forwarded.
    a_r2_all_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && space_q == '0) |=> out_valid);
    // R8: a sample arriving with a load is dropped.
    a_r8_load_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!out_valid && !($past(in_valid) && out_valid)));
endmodule

// File: tb/sim_scan_gate.sv
`timescale 1ns/1ps
module sim_scan_gate;
    localparam int DW = 16, LW = 3, SW = 2, CW = 3;

    logic          clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, cfg_continuous = 1'b0;
    logic [LW-1:0] cfg_chans = '0;
    logic [SW-1:0] cfg_space = '0;
    logic [CW-1:0] cfg_scans = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid, done;
    logic [DW-1:0] out_data;

    int n_run = 0, n_fail = 0;
    int m_L = 1, m_grp = 1, m_pos = 0, m_rem = 0, m_state = 0, m_cont = 0;

    always #2 clk = ~clk;

    scan_gate #(.DATA_W(DW), .LEN_W(LW), .SPC_W(SW), .SCAN_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_chans(cfg_chans),
        .cfg_space(cfg_space), .cfg_scans(cfg_scans), .cfg_continuous(cfg_continuous),
        .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .done(done));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One input cycle: update the model, cross the edge, compare the outputs.
    task automatic step(input string tag, input bit v, input logic [DW-1:0] d);
        bit acc, eov;
        in_valid = v;
        in_data  = d;
        acc = v && (m_state == 1);
        eov = acc && (m_pos < m_L);
        if (acc) begin
            m_pos = (m_pos + 1 == m_grp) ? 0 : m_pos + 1;
            if (m_cont == 0) begin
                m_rem--;
                if (m_rem == 0) m_state = 2;
            end
        end
        @(posedge clk); #1;
        chk(tag, "out_valid", int'(out_valid), int'(eov));
        if (eov) chk("R3", "out_data", int'(out_data), int'(d));
        chk((m_state == 2) ? "R6" : "R5", "done", int'(done), int'(m_state == 2));
    endtask

    task automatic load(input int L, input int D, input int S, input int cont, input bit v);
        cfg_chans = LW'(L); cfg_space = SW'(D); cfg_scans = CW'(S);
        cfg_continuous = cont[0]; cfg_load = 1'b1; in_valid = v; in_data = 16'hBEEF;
        m_L = L; m_grp = L * (1 + D); m_pos = 0; m_rem = S * m_grp; m_cont = cont;
        m_state = (cont == 0 && m_rem == 0) ? 2 : 1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        chk("R8", "out_valid after load", int'(out_valid), 0);
        chk((S == 0 && cont == 0) ? "R10" : "R8", "done after load", int'(done), int'(m_state == 2));
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "out_valid in reset", int'(out_valid), 0);
        chk("R9", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) step("R9", 1'b1, DW'(k + 100));

        // Counted-mode sweep, with input gaps.
        for (int L = 1; L <= 4; L++)
            for (int D = 0; D <= 3; D++)
                for (int S = 0; S <= 2; S++) begin
                    int n;
                    load(L, D, S, 0, 1'b1);
                    n = (S * L * (1 + D) * 5) / 4 + 8;
                    for (int k = 0; k < n; k++)
                        step((S == 0) ? "R10" : ((D == 0) ? "R2" : "R1"),
                             (k % 5) != 3, DW'(k * 37 + L * 5 + D));
                end

        // Continuous mode.
        for (int L = 1; L <= 4; L++)
            for (int D = 0; D <= 3; D++) begin
                load(L, D, 1, 1, 1'b0);
                for (int k = 0; k < 40; k++) step("R7", (k % 5) != 2, DW'(k * 11 + D));
            end

        // Long idle gap in the middle of a frame.
        load(2, 2, 0, 1, 1'b0);
        for (int k = 0; k < 3; k++)  step("R4", 1'b1, DW'(k + 1));
        for (int k = 0; k < 10; k++) step("R4", 1'b0, DW'(999));
        for (int k = 0; k < 8; k++)  step("R4", 1'b1, DW'(k + 50));

        // Reload in the middle of a frame, with a sample in the load cycle.
        load(3, 1, 0, 1, 1'b0);
        for (int k = 0; k < 4; k++) step("R8", 1'b1, DW'(k + 200));
        load(3, 1, 0, 1, 1'b1);
        for (int k = 0; k < 6; k++) step("R8", 1'b1, DW'(k + 300));

        // Reload after a counted run has finished.
        load(2, 1, 1, 0, 1'b0);
        for (int k = 0; k < 6; k++) step("R6", 1'b1, DW'(k + 400));
        load(1, 0, 2, 0, 1'b1);
        for (int k = 0; k < 4; k++) step("R8", 1'b1, DW'(k + 500));

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule